// File: doc/BRIEF.md
# Chained-Descriptor Memory-to-Stream DMA Channel

This block is one transmit DMA channel. Software places a chain of 8-byte descriptors in system memory, each naming a buffer address and a byte length, and starts the channel by writing the list address into the channel's low-address register. The channel then fetches each descriptor as two 32-bit words. It reads the buffer it describes one word at a time through a request/response memory port and presents the words in order on a valid/ready output stream. It moves on to the next descriptor 8 bytes further along.

The walk ends after a descriptor that carries the end-of-chain flag. Once the final word has left the stream, the channel raises a done flag. A descriptor that is not marked valid, or whose length is not a whole number of words, halts the walk and raises an error flag instead. Both flags are visible as ports and in a status register, and software clears them by writing ones. The memory port keeps at most one request in flight. The output stream holds its word for as long as the consumer is not ready.

Top module: `dma_tx_chain`

## Requirements
- R1: After a synchronous active-high reset, the status register reads 0. `done`, `err`, `out_valid` and `mem_req` are 0.
- R2: The register port decodes byte offsets with address bits [1:0] equal to zero; other accesses are ignored and read 0. The offsets are:
  - 0x00: high address word. It is read/write and has no effect on fetching.
  - 0x04: low address word. A write starts a walk when the channel is idle.
  - 0x08: status, with bit0 done, bit1 error and bit2 busy.
  
  Read data appears on `reg_rdata` one clock after `reg_addr` is presented.
- R3: A descriptor is two little-endian words.
  - The word at descriptor+0 holds the flags in bits [7:0]: bit0 valid, bit1 end of chain, bit5 transfer. It holds the byte length in bits [31:16].
  - The word at descriptor+4 holds the buffer address.
  
  Address bits [2:0] of the list address and bits [1:0] of the buffer address are treated as zero.
- R4: Descriptors are fetched back to back at list address, +8, +16 and so on. The walk stops after the descriptor with flag bit1 set.
- R5: A descriptor of length L reads L/4 words from buffer, buffer+4 and so on, and delivers them on the stream in that order. A memory request holds its address until granted, and only one request is outstanding.
- R6: After the end-of-chain descriptor has been processed and its last word accepted on the stream, `done` rises, and in the same cycle the busy status falls.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is unchanged.
- R8: A descriptor with flag bit0 clear, or with length bits [1:0] not zero, delivers no data. It ends the walk with `err` set and `done` not set. Words from earlier descriptors of the chain are still delivered.
- R9: A write to offset 0x04 while busy is ignored, and the running walk continues unchanged. The busy bit reads 1 during a walk.
- R10: A descriptor of length zero moves no data. It still advances to the next descriptor, or ends the chain if it is flagged last.
- R11: Writing a 1 to status bit0 clears done, and writing a 1 to bit1 clears error. Writing a 0 leaves the bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory byte address of the request |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response word |
| out_valid | output | 1 | Stream word valid |
| out_data | output | 32 | Stream word |
| out_ready | input | 1 | Stream consumer ready |
| done | output | 1 | Chain completed (write-1-to-clear) |
| err | output | 1 | Chain stopped on a bad descriptor (write-1-to-clear) |

## Verification
Single-descriptor chains are swept over every word count from zero to six. Each count is run under three output backpressure patterns and two memory grant patterns. This separates errors in word count and address stepping from errors in handshake timing.

A three-entry chain containing a zero-length middle entry shows whether the channel advances by 8 and skips data correctly. Invalid, misaligned-length and mid-chain-invalid descriptors tell an error stop apart from a normal completion. They also check that data delivered before the stop survives.

A restart attempt during a walk, unaligned list and buffer addresses, and selective flag clearing probe the register side.

// File: rtl/dmatx_pkg.sv
package dmatx_pkg;
  localparam int WORD_W    = 32;
  localparam int FLG_VALID = 0;
  localparam int FLG_LAST  = 1;
  localparam int LEN_LSB   = 16;
  localparam int IDX_HI    = 0;
  localparam int IDX_LO    = 1;
  localparam int IDX_STAT  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_D0_REQ, ST_D0_WAIT, ST_D1_REQ,
    ST_D1_WAIT, ST_DAT_REQ, ST_DAT_WAIT, ST_FIN
  } walk_st_t;
endpackage

// File: rtl/dmatx_regs.sv
module dmatx_regs
  import dmatx_pkg::*;
#(
  parameter int AW     = 32,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              busy,
  input  logic              done_p,
  input  logic              err_p,
  output logic              start,
  output logic [AW-1:0]     start_addr,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] reg_rdata
);
  localparam int IDX_W = REG_AW - 2;

  logic [IDX_W-1:0]  idx;
  logic              sel_ok;
  logic              wr_stat;
  logic [WORD_W-1:0] hi_q;
  logic [WORD_W-1:0] lo_q;

  assign idx        = reg_addr[REG_AW-1:2];
  assign sel_ok     = (reg_addr[1:0] == 2'b00);
  assign start      = reg_we && sel_ok && (idx == IDX_W'(IDX_LO)) && !busy;
  assign start_addr = reg_wdata[AW-1:0];
  assign wr_stat    = reg_we && sel_ok && (idx == IDX_W'(IDX_STAT));

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (reg_we && sel_ok && (idx == IDX_W'(IDX_HI)))
        hi_q <= reg_wdata;
      if (start)
        lo_q <= reg_wdata;
      if (done_p)
        done <= 1'b1;
      else if (wr_stat && reg_wdata[0])
        done <= 1'b0;
      if (err_p)
        err <= 1'b1;
      else if (wr_stat && reg_wdata[1])
        err <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (!sel_ok) begin
      reg_rdata <= '0;
    end else begin
      case (idx)
        IDX_W'(IDX_HI):   reg_rdata <= hi_q;
        IDX_W'(IDX_LO):   reg_rdata <= lo_q;
        IDX_W'(IDX_STAT): reg_rdata <= {{(WORD_W-3){1'b0}}, busy, err, done};
        default:          reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dmatx_walker.sv
module dmatx_walker
  import dmatx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  output logic              busy,
  output logic              done_p,
  output logic              err_p,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              out_busy,
  output logic              ld,
  output logic [WORD_W-1:0] ld_data
);
  localparam int CNT_W   = LEN_W - 2;
  localparam int LEN_MSB = LEN_LSB + LEN_W - 1;

  walk_st_t         st;
  logic [AW-1:0]    ptr;
  logic [AW-1:0]    buf_addr;
  logic [CNT_W-1:0] wleft;
  logic             last_q;
  logic             bad_desc;

  assign bad_desc = !mem_rdata[FLG_VALID] || (mem_rdata[LEN_LSB+1:LEN_LSB] != 2'b00);
  assign busy     = (st != ST_IDLE);
  assign done_p   = (st == ST_FIN) && !out_busy;
  assign err_p    = (st == ST_D0_WAIT) && mem_rvalid && bad_desc;
  assign ld       = (st == ST_DAT_WAIT) && mem_rvalid;
  assign ld_data  = mem_rdata;

  always_comb begin
    mem_req  = 1'b0;
    mem_addr = buf_addr;
    case (st)
      ST_D0_REQ: begin
        mem_req  = 1'b1;
        mem_addr = ptr;
      end
      ST_D1_REQ: begin
        mem_req  = 1'b1;
        mem_addr = ptr + AW'(4);
      end
      ST_DAT_REQ: mem_req = !out_busy;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ptr      <= '0;
      buf_addr <= '0;
      wleft    <= '0;
      last_q   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE:
          if (start) begin
            ptr <= start_addr & ~AW'(7);
            st  <= ST_D0_REQ;
          end
        ST_D0_REQ:
          if (mem_gnt) st <= ST_D0_WAIT;
        ST_D0_WAIT:
          if (mem_rvalid) begin
            last_q <= mem_rdata[FLG_LAST];
            wleft  <= mem_rdata[LEN_MSB:LEN_LSB+2];
            st     <= bad_desc ? ST_IDLE : ST_D1_REQ;
          end
        ST_D1_REQ:
          if (mem_gnt) st <= ST_D1_WAIT;
        ST_D1_WAIT:
          if (mem_rvalid) begin
            buf_addr <= mem_rdata[AW-1:0] & ~AW'(3);
            if (wleft != '0)
              st <= ST_DAT_REQ;
            else if (last_q)
              st <= ST_FIN;
            else begin
              ptr <= ptr + AW'(8);
              st  <= ST_D0_REQ;
            end
          end
        ST_DAT_REQ:
          if (mem_req && mem_gnt) st <= ST_DAT_WAIT;
        ST_DAT_WAIT:
          if (mem_rvalid) begin
            buf_addr <= buf_addr + AW'(4);
            wleft    <= wleft - CNT_W'(1);
            if (wleft != CNT_W'(1))
              st <= ST_DAT_REQ;
            else if (last_q)
              st <= ST_FIN;
            else begin
              ptr <= ptr + AW'(8);
              st  <= ST_D0_REQ;
            end
          end
        ST_FIN:
          if (!out_busy) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmatx_outreg.sv
module dmatx_outreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (ld) begin
      out_valid <= 1'b1;
      out_data  <= ld_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_tx_chain.sv
module dma_tx_chain
  import dmatx_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LEN_W  = 16,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              out_ready,
  output logic              done,
  output logic              err
);
  logic              walk_busy;
  logic              done_p;
  logic              err_p;
  logic              start;
  logic [AW-1:0]     start_addr;
  logic              ld;
  logic [WORD_W-1:0] ld_data;

  dmatx_regs #(.AW(AW), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(walk_busy), .done_p(done_p),
    .err_p(err_p), .start(start), .start_addr(start_addr),
    .done(done), .err(err), .reg_rdata(reg_rdata)
  );

  dmatx_walker #(.AW(AW), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .busy(walk_busy), .done_p(done_p), .err_p(err_p),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_busy(out_valid), .ld(ld), .ld_data(ld_data)
  );

  dmatx_outreg #(.W(WORD_W)) u_out (
    .clk(clk), .rst(rst), .ld(ld), .ld_data(ld_data),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );
endmodule

// File: rtl/dmatx_chk.sv
module dmatx_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          walk_busy,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_gnt,
  input logic          out_valid,
  input logic [31:0]   out_data,
  input logic          out_ready,
  input logic          done,
  input logic          err
);
  // R5: no memory traffic while idle
  a_r5_idle_no_req: assert property (@(posedge clk) disable iff (rst)
    !walk_busy |-> !mem_req);

  // R5: an ungranted request holds its address
  a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

  // R3: every fetch is word aligned
  a_r3_word_align: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R7: a stalled word is held
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R6: completion only when idle and drained
  a_r6_done_drained: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !walk_busy && !out_valid);

  // R8: an error stop never signals completion at the same time
  a_r8_err_excl: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !$rose(done));
endmodule

bind dma_tx_chain dmatx_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .walk_busy(walk_busy), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_gnt(mem_gnt), .out_valid(out_valid),
  .out_data(out_data), .out_ready(out_ready), .done(done), .err(err)
);

// File: tb/sim_dma_tx_chain.sv
`timescale 1ns/1ps
module sim_dma_tx_chain;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_gnt;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready;
  logic        done;
  logic        err;

  always #2.5 clk = ~clk;

  dma_tx_chain u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .done(done), .err(err)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int gnt_mode = 0;
  int rdy_mode = 0;
  int rx_n = 0;
  bit finished = 0;
  logic [31:0] dmem [0:63];
  logic [31:0] rx [0:511];
  logic [31:0] ex [0:511];
  int ex_n;
  bit ex_err;
  bit acc_pend;
  logic [31:0] acc_addr;
  bit hold_chk;
  logic [31:0] hold_data;

  function automatic logic [31:0] fdat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    if (a < 32'h100) return dmem[a[7:2]];
    return fdat(a);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder and stream consumer, all driven at the falling edge
  initial begin
    mem_gnt = 0; mem_rvalid = 0; mem_rdata = 0; out_ready = 0;
    acc_pend = 0; hold_chk = 0; acc_addr = 0; hold_data = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (hold_chk) chk(out_valid && out_data == hold_data, "R7 stall hold", out_data, hold_data);
      mem_rvalid = 0;
      if (acc_pend) begin
        mem_rvalid = 1;
        mem_rdata = rd_mem(acc_addr);
        acc_pend = 0;
      end
      mem_gnt = (gnt_mode == 0) ? 1'b1 : (cyc % 3 == 0);
      if (mem_req && mem_gnt) begin
        acc_pend = 1;
        acc_addr = mem_addr;
      end
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 2 == 0);
        default: out_ready = (cyc % 5 == 4);
      endcase
      if (out_valid && out_ready && rx_n < 512) begin
        rx[rx_n] = out_data;
        rx_n++;
      end
      hold_chk = out_valid && !out_ready;
      hold_data = out_data;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic put_desc(input int idx, input logic [7:0] flg,
                          input logic [15:0] len, input logic [31:0] ba);
    dmem[idx*2]   = {len, 8'h00, flg};
    dmem[idx*2+1] = ba;
  endtask

  task automatic build_exp(input logic [31:0] sa);
    logic [31:0] p, w0, b;
    p = sa & ~32'd7;
    ex_n = 0;
    ex_err = 0;
    while (p < 32'h100) begin
      w0 = dmem[p[7:2]];
      if (!w0[0] || w0[17:16] != 2'b00) begin
        ex_err = 1;
        break;
      end
      b = dmem[p[7:2] + 1] & ~32'd3;
      for (int k = 0; k < int'(w0[31:18]); k++) begin
        ex[ex_n] = fdat(b + 32'(4 * k));
        ex_n++;
      end
      if (w0[1]) break;
      p = p + 8;
    end
  endtask

  task automatic finish_walk(input logic [31:0] sa, input string tag);
    int t = 0;
    logic [31:0] s;
    while (!(done || err) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    build_exp(sa);
    chk(done == !ex_err, {tag, " R6/R8 done flag"}, 32'(done), 32'(!ex_err));
    chk(err == ex_err, {tag, " R8 err flag"}, 32'(err), 32'(ex_err));
    chk(rx_n == ex_n, {tag, " R5 word count"}, 32'(rx_n), 32'(ex_n));
    for (int i = 0; i < ex_n && i < rx_n; i++)
      chk(rx[i] == ex[i], {tag, " R5 data order"}, rx[i], ex[i]);
    rd(4'h8, s);
    chk(s[2] == 1'b0, {tag, " R6 busy low after end"}, s, {29'b0, 1'b0, 1'(ex_err), 1'(!ex_err)});
    wr(4'h8, 32'h3);
    chk(!done && !err, {tag, " R11 flags cleared"}, {30'b0, err, done}, 32'h0);
  endtask

  task automatic run(input logic [31:0] sa, input string tag);
    rx_n = 0;
    wr(4'h4, sa);
    finish_walk(sa, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
    rst = 1; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    repeat (5) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk(!done && !err && !out_valid && !mem_req, "R1 reset outputs",
        {28'b0, mem_req, out_valid, err, done}, 32'h0);
    rd(4'h8, s);
    chk(s == 32'h0, "R1 status after reset", s, 32'h0);

    // R2 high word read back, no start
    wr(4'h0, 32'hDEAD0001);
    rd(4'h0, s);
    chk(s == 32'hDEAD0001, "R2 high word readback", s, 32'hDEAD0001);
    rd(4'h8, s);
    chk(s == 32'h0, "R2 high write does not start", s, 32'h0);
    rd(4'h1, s);
    chk(s == 32'h0, "R2 unaligned offset reads zero", s, 32'h0);

    // R4 R10 chain of three with a zero-length middle entry
    put_desc(0, 8'h21, 16'd8,  32'h1000);
    put_desc(1, 8'h21, 16'd0,  32'h1100);
    put_desc(2, 8'h23, 16'd12, 32'h1200);
    put_desc(3, 8'h21, 16'd4,  32'h1300);
    run(32'h0, "R4 R10 chain");
    chk(rx_n == 5, "R10 zero length moves nothing", 32'(rx_n), 32'd5);
    rd(4'h4, s);
    chk(s == 32'h0, "R2 low word readback", s, 32'h0);

    // R5 R7 sweep: one descriptor, 0..6 words, all pacing patterns
    for (int n = 0; n <= 6; n++)
      for (int r = 0; r < 3; r++)
        for (int g = 0; g < 2; g++) begin
          rdy_mode = r; gnt_mode = g;
          put_desc(8, 8'h23, 16'(4 * n), 32'h2000 + 32'(n * 256));
          run(32'h40, "R5 R7 sweep");
        end

    // R3 unaligned list and buffer addresses
    rdy_mode = 1; gnt_mode = 1;
    put_desc(10, 8'h23, 16'd12, 32'h3003);
    run(32'h55, "R3 unaligned");
    chk(rx_n == 3 && rx[0] == fdat(32'h3000), "R3 address masking", rx[0], fdat(32'h3000));

    // R8 invalid descriptor
    rdy_mode = 0; gnt_mode = 0;
    put_desc(12, 8'h22, 16'd8, 32'h4000);
    run(32'h60, "R8 invalid flag");
    put_desc(14, 8'h23, 16'd6, 32'h4100);
    run(32'h70, "R8 odd length");
    put_desc(16, 8'h21, 16'd8, 32'h4200);
    put_desc(17, 8'h22, 16'd8, 32'h4300);
    run(32'h80, "R8 mid-chain stop");
    chk(rx_n == 2, "R8 earlier words kept", 32'(rx_n), 32'd2);

    // R9 restart ignored while busy
    rdy_mode = 2; gnt_mode = 1;
    put_desc(20, 8'h23, 16'd24, 32'h5000);
    put_desc(22, 8'h23, 16'd4,  32'h6000);
    rx_n = 0;
    wr(4'h4, 32'hA0);
    rd(4'h8, s);
    chk(s[2] == 1'b1, "R9 busy reads one", s, 32'h4);
    wr(4'h4, 32'hB0);
    finish_walk(32'hA0, "R9 restart ignored");

    // R11 selective clearing
    rdy_mode = 0; gnt_mode = 0;
    rx_n = 0;
    wr(4'h4, 32'hB0);
    while (!done) @(negedge clk);
    wr(4'h8, 32'h2);
    chk(done == 1'b1, "R11 writing err bit keeps done", 32'(done), 32'h1);
    wr(4'h8, 32'h1);
    chk(done == 1'b0, "R11 writing done bit clears", 32'(done), 32'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule